// File: doc/BRIEF.md
# CAN Controller Low-Power Entry Sequencer

This block sequences a CAN controller into and out of its low-power states. A low-power request comes from the module-off control bit or from a system-wide doze request. A doze request counts only when the doze-allow bit was already set. In normal operation the sequencer waits for a safe point on the bus, then waits for internal transfers to finish. Only then does it stop the protocol-engine and host-interface clocks, isolate the bus pins and acknowledge.

When the controller is already frozen, the sequencer skips the bus and drain waits. It gates at once and also clears the freeze acknowledge. On exit it lets the clocks restart first. It drops the acknowledge and not-ready flags only after the protocol engine reports that its clock is running again.

While the acknowledge is high, the sequencer also guards host accesses to the mask registers and the message RAM. A blocked access gets an error response, reads as zero and has its write suppressed.

Top module: `canlp_seq`

## Requirements
- R1: After reset, every control output is low: clock stops, not-ready, acknowledge, freeze-acknowledge clear, receive block and transmit force-recessive.
- R2: A doze request starts entry only when `sys_doze_req` is high and `doze_allow` is high now and was also high in the previous cycle. `sys_doze_req` alone has no effect. Dropping either input ends doze.
- R3: Outside freeze, entry leaves its bus wait only at a safe point. `pe_bus_st` 00 means idle and 10 means bus-off; both are safe. 01 and 11 mean active traffic. A `pe_ifs3` strobe is also safe, but only when it comes with `pe_rx_lvl` = 1 (recessive).
- R4: After the safe point, gating waits until all of `pe_busy_arb`, `pe_busy_match`, `pe_busy_movein` and `pe_busy_moveout` are low.
- R5: With an idle, quiet bus, both clock-stop outputs, `rx_block` and `tx_force_rec` rise three cycles after the request. `lp_ack` and `not_ready` rise one cycle after that.
- R6: A request while `frz_active` is high bypasses the bus and drain waits. Clock stops rise one cycle after the request. `lp_ack`, `not_ready` and `frz_ack_clr` rise the cycle after that.
- R7: While `lp_ack` is high, an access to word address 0x010–0x013 or 0x020–0x23F is blocked: `acc_err` = 1, `acc_wr_en` = 0 and `acc_rdata` = 0. All other addresses, and every address while `lp_ack` is low, pass through.
- R8: One cycle after the request is removed, the clock stops fall. `lp_ack`, `not_ready`, `rx_block`, `tx_force_rec` and `frz_ack_clr` stay high until `pe_clk_live` is seen high, and fall one cycle later.
- R9: A request withdrawn before the clocks are stopped returns the block to normal running with no acknowledge.
- R10: The clock-stop outputs and `lp_ack` never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_off_req | input | 1 | Module-off request bit |
| doze_allow | input | 1 | Doze-allow control bit |
| sys_doze_req | input | 1 | System-wide doze request |
| frz_active | input | 1 | Controller is in freeze |
| pe_bus_st | input | 2 | Bus state from protocol engine |
| pe_ifs3 | input | 1 | Strobe at third intermission bit |
| pe_rx_lvl | input | 1 | Sampled bus level, 1 = recessive |
| pe_busy_arb | input | 1 | Arbitration in progress |
| pe_busy_match | input | 1 | Matching in progress |
| pe_busy_movein | input | 1 | Move-in in progress |
| pe_busy_moveout | input | 1 | Move-out in progress |
| pe_clk_live | input | 1 | Protocol engine reports running clock |
| acc_valid | input | 1 | Host access strobe |
| acc_we | input | 1 | Host access is a write |
| acc_addr | input | AW | Host word address |
| ram_rdata | input | DW | Read data from register/RAM path |
| pe_clk_stop | output | 1 | Stop protocol-engine clock |
| host_clk_stop | output | 1 | Stop host-interface submodule clock |
| not_ready | output | 1 | Not-ready flag |
| lp_ack | output | 1 | Low-power acknowledge |
| frz_ack_clr | output | 1 | Clear freeze acknowledge |
| rx_block | output | 1 | Ignore receive input |
| tx_force_rec | output | 1 | Force transmit recessive |
| acc_err | output | 1 | Blocked access error response |
| acc_wr_en | output | 1 | Write allowed to reach storage |
| acc_rdata | output | DW | Read data returned to host |

## Verification
Every control output comes from a register.

- With a clean bus, the clock stops are due three rising edges after the request and the acknowledge four. Frozen entry takes one and two edges.
- The sequencer leaves its bus wait on the same edge that samples the safe point, and leaves its drain wait on the same edge that samples the last busy flag low.
- Exit drops the clock stops one edge after the request falls, and drops the acknowledge one edge after `pe_clk_live` is seen high.
- The access outputs are combinational, so they are checked in the same cycle as the access.

The bench queues each expectation under the exact number of rising edges after it drives an input at a falling edge. The monitor compares the outputs 1 ns after the edge it counted.

// File: rtl/canlp_pkg.sv
package canlp_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SAFE  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_GATED = 3'd3,
    ST_WAKE  = 3'd4
  } seq_st_e;

  localparam logic [1:0] BUS_IDLE = 2'b00;
  localparam logic [1:0] BUS_OFF  = 2'b10;
endpackage

// File: rtl/canlp_rst_sync.sv
module canlp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/canlp_trigger.sv
module canlp_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_off_req,
  input  logic doze_allow,
  input  logic sys_doze_req,
  output logic lp_req
);
  logic allow_q;

  // doze_allow must have been set in the previous cycle as well
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) allow_q <= 1'b0;
    else        allow_q <= doze_allow;
  end

  assign lp_req = mod_off_req | (sys_doze_req & doze_allow & allow_q);
endmodule

// File: rtl/canlp_fsm.sv
module canlp_fsm
  import canlp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_req,
  input  logic       frz_active,
  input  logic [1:0] pe_bus_st,
  input  logic       pe_ifs3,
  input  logic       pe_rx_lvl,
  input  logic [3:0] busy_vec,
  input  logic       pe_clk_live,
  output logic       clk_stop,
  output logic       isolate,
  output logic       ack,
  output logic       frz_clr
);
  seq_st_e st_q, st_d;
  logic    ack_q, ack_d;
  logic    via_frz_q, via_frz_d;
  logic    fclr_q, fclr_d;
  logic    safe_pt, drained;

  assign safe_pt = (pe_bus_st == BUS_IDLE) || (pe_bus_st == BUS_OFF) ||
                   (pe_ifs3 && pe_rx_lvl);
  assign drained = ~|busy_vec;

  // next state
  always_comb begin
    st_d      = st_q;
    via_frz_d = via_frz_q;
    unique case (st_q)
      ST_RUN: begin
        if (lp_req) begin
          if (frz_active) begin
            st_d      = ST_GATED;
            via_frz_d = 1'b1;
          end else begin
            st_d = ST_SAFE;
          end
        end
      end
      ST_SAFE: begin
        if (!lp_req)      st_d = ST_RUN;
        else if (safe_pt) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!lp_req)      st_d = ST_RUN;
        else if (drained) st_d = ST_GATED;
      end
      ST_GATED: begin
        // leave only once the acknowledge is registered, so stop and ack never move together
        if (!lp_req && ack_q) st_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (pe_clk_live) begin
          st_d      = ST_RUN;
          via_frz_d = 1'b0;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  // acknowledge next values
  always_comb begin
    ack_d  = ack_q;
    fclr_d = fclr_q;
    if (st_q == ST_GATED) begin
      ack_d  = 1'b1;
      fclr_d = via_frz_q;
    end else if (st_q == ST_WAKE && pe_clk_live) begin
      ack_d  = 1'b0;
      fclr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_RUN;
      ack_q     <= 1'b0;
      via_frz_q <= 1'b0;
      fclr_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      ack_q     <= ack_d;
      via_frz_q <= via_frz_d;
      fclr_q    <= fclr_d;
    end
  end

  assign clk_stop = (st_q == ST_GATED);
  assign isolate  = (st_q == ST_GATED) || (st_q == ST_WAKE);
  assign ack      = ack_q;
  assign frz_clr  = fclr_q;
endmodule

// File: rtl/canlp_acc_guard.sv
module canlp_acc_guard #(
  parameter int              AW     = 10,
  parameter int              DW     = 32,
  parameter int              NRGN   = 2,
  parameter logic [NRGN*AW-1:0] RGN_LO = {10'h020, 10'h010},
  parameter logic [NRGN*AW-1:0] RGN_HI = {10'h23F, 10'h013}
) (
  input  logic          lp_active,
  input  logic          acc_valid,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] ram_rdata,
  output logic          acc_err,
  output logic          acc_wr_en,
  output logic [DW-1:0] acc_rdata
);
  logic [NRGN-1:0] hit;
  logic            blocked;

  for (genvar g = 0; g < NRGN; g++) begin : g_rgn
    assign hit[g] = (acc_addr >= RGN_LO[g*AW +: AW]) && (acc_addr <= RGN_HI[g*AW +: AW]);
  end

  assign blocked   = lp_active && (|hit);
  assign acc_err   = acc_valid && blocked;
  assign acc_wr_en = acc_valid && acc_we && !blocked;
  assign acc_rdata = blocked ? '0 : ram_rdata;
endmodule

// File: rtl/canlp_seq.sv
module canlp_seq #(
  parameter int                 AW     = 10,
  parameter int                 DW     = 32,
  parameter int                 NRGN   = 2,
  parameter logic [NRGN*AW-1:0] RGN_LO = {10'h020, 10'h010},
  parameter logic [NRGN*AW-1:0] RGN_HI = {10'h23F, 10'h013}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mod_off_req,
  input  logic          doze_allow,
  input  logic          sys_doze_req,
  input  logic          frz_active,
  input  logic [1:0]    pe_bus_st,
  input  logic          pe_ifs3,
  input  logic          pe_rx_lvl,
  input  logic          pe_busy_arb,
  input  logic          pe_busy_match,
  input  logic          pe_busy_movein,
  input  logic          pe_busy_moveout,
  input  logic          pe_clk_live,
  input  logic          acc_valid,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] ram_rdata,
  output logic          pe_clk_stop,
  output logic          host_clk_stop,
  output logic          not_ready,
  output logic          lp_ack,
  output logic          frz_ack_clr,
  output logic          rx_block,
  output logic          tx_force_rec,
  output logic          acc_err,
  output logic          acc_wr_en,
  output logic [DW-1:0] acc_rdata
);
  logic rst_sync_n;
  logic lp_req;
  logic clk_stop, isolate, ack, frz_clr;

  canlp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  canlp_trigger u_trig (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mod_off_req  (mod_off_req),
    .doze_allow   (doze_allow),
    .sys_doze_req (sys_doze_req),
    .lp_req       (lp_req)
  );

  canlp_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .lp_req      (lp_req),
    .frz_active  (frz_active),
    .pe_bus_st   (pe_bus_st),
    .pe_ifs3     (pe_ifs3),
    .pe_rx_lvl   (pe_rx_lvl),
    .busy_vec    ({pe_busy_arb, pe_busy_match, pe_busy_movein, pe_busy_moveout}),
    .pe_clk_live (pe_clk_live),
    .clk_stop    (clk_stop),
    .isolate     (isolate),
    .ack         (ack),
    .frz_clr     (frz_clr)
  );

  canlp_acc_guard #(
    .AW(AW), .DW(DW), .NRGN(NRGN), .RGN_LO(RGN_LO), .RGN_HI(RGN_HI)
  ) u_guard (
    .lp_active (ack),
    .acc_valid (acc_valid),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .ram_rdata (ram_rdata),
    .acc_err   (acc_err),
    .acc_wr_en (acc_wr_en),
    .acc_rdata (acc_rdata)
  );

  assign pe_clk_stop   = clk_stop;
  assign host_clk_stop = clk_stop;
  assign not_ready     = ack;
  assign lp_ack        = ack;
  assign frz_ack_clr   = frz_clr;
  assign rx_block      = isolate;
  assign tx_force_rec  = isolate;
endmodule

// File: rtl/canlp_seq_chk.sv
module canlp_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pe_clk_live,
  input logic          pe_clk_stop,
  input logic          host_clk_stop,
  input logic          lp_ack,
  input logic          frz_ack_clr,
  input logic          rx_block,
  input logic          tx_force_rec,
  input logic          acc_err,
  input logic          acc_wr_en,
  input logic [DW-1:0] acc_rdata
);
  a_r10_stop_ack_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pe_clk_stop) |-> $stable(lp_ack));

  a_r5_ack_while_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_ack) |-> pe_clk_stop);

  a_r5_isolated_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    pe_clk_stop |-> (host_clk_stop && rx_block && tx_force_rec));

  a_r8_ack_drop_after_live: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lp_ack) |-> ($past(pe_clk_live) && !pe_clk_stop));

  a_r7_err_only_in_low_power: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> lp_ack);

  a_r7_blocked_is_inert: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_rdata == '0 && !acc_wr_en));

  a_r6_frz_clr_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    frz_ack_clr |-> lp_ack);
endmodule

bind canlp_seq canlp_seq_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pe_clk_live   (pe_clk_live),
  .pe_clk_stop   (pe_clk_stop),
  .host_clk_stop (host_clk_stop),
  .lp_ack        (lp_ack),
  .frz_ack_clr   (frz_ack_clr),
  .rx_block      (rx_block),
  .tx_force_rec  (tx_force_rec),
  .acc_err       (acc_err),
  .acc_wr_en     (acc_wr_en),
  .acc_rdata     (acc_rdata)
);

// File: tb/canlp_seq_tb.sv
`timescale 1ns/1ps
module canlp_seq_tb;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam logic [9:0] CTRL = 10'b1111111000;
  localparam logic [9:0] ACC  = 10'b0000000111;
  localparam logic [9:0] ZERO = 10'b0;

  logic clk = 1'b0;
  logic rst_n;
  logic mod_off_req, doze_allow, sys_doze_req, frz_active;
  logic [1:0] pe_bus_st;
  logic pe_ifs3, pe_rx_lvl;
  logic pe_busy_arb, pe_busy_match, pe_busy_movein, pe_busy_moveout;
  logic pe_clk_live;
  logic acc_valid, acc_we;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] ram_rdata;
  logic pe_clk_stop, host_clk_stop, not_ready, lp_ack, frz_ack_clr;
  logic rx_block, tx_force_rec, acc_err, acc_wr_en;
  logic [DW-1:0] acc_rdata;

  always #2 clk = ~clk;

  canlp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mod_off_req(mod_off_req), .doze_allow(doze_allow),
    .sys_doze_req(sys_doze_req), .frz_active(frz_active), .pe_bus_st(pe_bus_st),
    .pe_ifs3(pe_ifs3), .pe_rx_lvl(pe_rx_lvl), .pe_busy_arb(pe_busy_arb),
    .pe_busy_match(pe_busy_match), .pe_busy_movein(pe_busy_movein),
    .pe_busy_moveout(pe_busy_moveout), .pe_clk_live(pe_clk_live),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr), .ram_rdata(ram_rdata),
    .pe_clk_stop(pe_clk_stop), .host_clk_stop(host_clk_stop), .not_ready(not_ready),
    .lp_ack(lp_ack), .frz_ack_clr(frz_ack_clr), .rx_block(rx_block),
    .tx_force_rec(tx_force_rec), .acc_err(acc_err), .acc_wr_en(acc_wr_en),
    .acc_rdata(acc_rdata)
  );

  typedef struct {
    int         cyc;
    string      req;
    logic [9:0] exp;
    logic [9:0] msk;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic logic [9:0] snap();
    return {pe_clk_stop, host_clk_stop, not_ready, lp_ack, frz_ack_clr,
            rx_block, tx_force_rec, acc_err, acc_wr_en, (acc_rdata == '0)};
  endfunction

  // {stop, stop, ack, ack, frz_clr, iso, iso, 3'b0}
  function automatic logic [9:0] cv(bit g, bit a, bit iso, bit f);
    return {g, g, a, a, f, iso, iso, 3'b000};
  endfunction

  function automatic logic [9:0] av(bit e, bit w, bit rz);
    return {7'b0, e, w, rz};
  endfunction

  // driver side: queue an expectation n rising edges from now, kept in cycle order
  task automatic push(int n, string req, logic [9:0] e, logic [9:0] m);
    item_t it;
    int pos;
    it.cyc = cyc + n; it.req = req; it.exp = e; it.msk = m;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > it.cyc) begin pos = i; break; end
    end
    q.insert(pos, it);
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // monitor: count edges, compare due items 1 ns after the edge
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (((snap() ^ it.exp) & it.msk) != 0) begin
        failures++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                 it.req, cyc, snap() & it.msk, it.exp & it.msk, it.msk);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mod_off_req = 0; doze_allow = 0; sys_doze_req = 0; frz_active = 0;
    pe_bus_st = 2'b00; pe_ifs3 = 0; pe_rx_lvl = 0;
    pe_busy_arb = 0; pe_busy_match = 0; pe_busy_movein = 0; pe_busy_moveout = 0;
    pe_clk_live = 0; acc_valid = 0; acc_we = 0; acc_addr = '0; ram_rdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    push(1, "R1", cv(0, 0, 0, 0), CTRL);
    tick(2);

    // R5 idle-bus entry via module-off
    mod_off_req = 1;
    push(2, "R5", cv(0, 0, 0, 0), CTRL);
    push(3, "R5", cv(1, 0, 1, 0), CTRL);
    push(4, "R5", cv(1, 1, 1, 0), CTRL);
    tick(6);

    // R7 access guard while acknowledged
    ram_rdata = 32'hA5A5_0001;
    acc_valid = 1; acc_we = 1; acc_addr = 10'h011;
    push(1, "R7", av(1, 0, 1), ACC); tick();
    acc_addr = 10'h014;
    push(1, "R7", av(0, 1, 0), ACC); tick();
    acc_we = 0; acc_addr = 10'h23F;
    push(1, "R7", av(1, 0, 1), ACC); tick();
    acc_addr = 10'h240;
    push(1, "R7", av(0, 0, 0), ACC); tick();
    acc_we = 1; acc_addr = 10'h010;
    push(1, "R7", av(1, 0, 1), ACC); tick();
    acc_addr = 10'h011;

    // R8 exit waits for live clock
    mod_off_req = 0;
    push(1, "R10", cv(0, 1, 1, 0), CTRL);
    push(5, "R8", cv(0, 1, 1, 0), CTRL);
    tick(6);
    pe_clk_live = 1;
    push(1, "R8", cv(0, 0, 0, 0), CTRL);
    push(2, "R7", av(0, 1, 0), ACC);
    tick(3);
    acc_valid = 0;

    // R2 doze with allow set beforehand
    doze_allow = 1; tick(3);
    sys_doze_req = 1;
    push(3, "R2", cv(1, 0, 1, 0), CTRL);
    push(4, "R2", cv(1, 1, 1, 0), CTRL);
    tick(6);
    doze_allow = 0;
    push(1, "R2", cv(0, 1, 1, 0), CTRL);
    push(2, "R2", cv(0, 0, 0, 0), CTRL);
    tick(4);
    // R2 global request alone ignored
    tick(6);
    push(1, "R2", cv(0, 0, 0, 0), CTRL);
    tick(2);
    // R2 allow and request together: one extra cycle
    sys_doze_req = 0; tick(2);
    doze_allow = 1; sys_doze_req = 1;
    push(4, "R2", cv(1, 0, 1, 0), CTRL);
    push(5, "R2", cv(1, 1, 1, 0), CTRL);
    tick(7);
    sys_doze_req = 0;
    push(1, "R2", cv(0, 1, 1, 0), CTRL);
    push(2, "R2", cv(0, 0, 0, 0), CTRL);
    tick(4);
    doze_allow = 0;

    // R3 active bus holds, dominant intermission bit is not safe
    pe_bus_st = 2'b01; mod_off_req = 1;
    tick(8);
    push(1, "R3", cv(0, 0, 0, 0), CTRL);
    tick(2);
    pe_ifs3 = 1; pe_rx_lvl = 0; tick();
    pe_ifs3 = 0;
    push(4, "R3", cv(0, 0, 0, 0), CTRL);
    tick(5);
    pe_ifs3 = 1; pe_rx_lvl = 1;
    push(2, "R3", cv(1, 0, 1, 0), CTRL);
    push(3, "R3", cv(1, 1, 1, 0), CTRL);
    tick();
    pe_ifs3 = 0; pe_rx_lvl = 0;
    tick(4);
    mod_off_req = 0;
    push(2, "R8", ZERO, CTRL);
    tick(4);

    // R3 bus-off is safe
    pe_bus_st = 2'b10; mod_off_req = 1;
    push(3, "R3", cv(1, 0, 1, 0), CTRL);
    push(4, "R3", cv(1, 1, 1, 0), CTRL);
    tick(6);
    mod_off_req = 0;
    push(2, "R8", ZERO, CTRL);
    tick(4);

    // R3 state 11 counts as active
    pe_bus_st = 2'b11; mod_off_req = 1;
    tick(6);
    push(1, "R3", ZERO, CTRL);
    tick();
    pe_bus_st = 2'b00;
    push(2, "R3", cv(1, 0, 1, 0), CTRL);
    push(3, "R3", cv(1, 1, 1, 0), CTRL);
    tick(5);
    mod_off_req = 0;
    push(2, "R8", ZERO, CTRL);
    tick(4);

    // R4 drain of every busy flag
    pe_busy_arb = 1; pe_busy_moveout = 1; mod_off_req = 1;
    tick(6);
    push(1, "R4", ZERO, CTRL);
    tick(2);
    pe_busy_arb = 0; tick(4);
    push(1, "R4", ZERO, CTRL);
    tick(2);
    pe_busy_moveout = 0; pe_busy_match = 1; pe_busy_movein = 1;
    tick(4);
    push(1, "R4", ZERO, CTRL);
    tick();
    pe_busy_match = 0; pe_busy_movein = 0;
    push(1, "R4", cv(1, 0, 1, 0), CTRL);
    push(2, "R4", cv(1, 1, 1, 0), CTRL);
    tick(4);
    mod_off_req = 0;
    push(2, "R8", ZERO, CTRL);
    tick(4);

    // R6 freeze shortcut ignores bus and busy
    frz_active = 1; pe_bus_st = 2'b01; pe_busy_arb = 1; mod_off_req = 1;
    push(1, "R6", cv(1, 0, 1, 0), CTRL);
    push(2, "R6", cv(1, 1, 1, 1), CTRL);
    tick(4);
    mod_off_req = 0;
    push(1, "R6", cv(0, 1, 1, 1), CTRL);
    push(2, "R6", ZERO, CTRL);
    tick(4);
    frz_active = 0; pe_busy_arb = 0;

    // R9 abort while waiting for safe point
    mod_off_req = 1; tick(3);
    mod_off_req = 0; tick();
    pe_bus_st = 2'b00;
    push(1, "R9", ZERO, CTRL);
    push(5, "R9", ZERO, CTRL);
    tick(6);
    // R9 abort while draining
    pe_busy_arb = 1; mod_off_req = 1; tick(3);
    mod_off_req = 0; tick();
    pe_busy_arb = 0;
    push(4, "R9", ZERO, CTRL);
    tick(6);

    while (q.size() > 0) tick();
    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule